// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a memory-mapped watchdog with a small 32-bit register bus. It runs on the system clock and counts down on a slow tick enable that arrives at 32768 Hz. Software sets a timeout, turns the counter on, and must reload it before it runs out. When the counter runs out, the block drives a fixed-length reset pulse, raises an interrupt, or does both in turn, as the control bits select. A failed write leaves no mark on the block. Every write that changes behaviour must carry a magic key, and writes with a wrong key are dropped. A separate keyed write forces a reset at once. A clear-on-read cause register tells software why the last reset happened.

The timeout is set in units of 512 ticks, which is 15.625 ms per unit at 32768 Hz. The unit field is 10 bits wide. Reads return data one clock after the read strobe.

Top module: `kwd_timer`

Register offsets (byte addresses): CTRL 0x00, PERIOD 0x04, KICK 0x08, CAUSE 0x0C, COUNT 0x10 (current counter, read-only), FORCE 0x14.

## Requirements
- R1: After reset: CTRL reads 0, PERIOD reads 0x7FE0 (length 1023), COUNT reads 523776, CAUSE reads 0, irq_o is 0 and wdt_rst_o is 1 (idle level for active-low).
- R2: A CTRL write takes effect only if wdata[31:24] is 0x22. It then loads enable (bit 0), polarity (bit 1), reset-output enable (bit 2), interrupt mode (bit 3) and dual mode (bit 6). CTRL reads back those bits at the same positions. A write with any other key leaves CTRL unchanged.
- R3: A PERIOD write takes effect only if wdata[4:0] is exactly 0x08. The length is taken from wdata[14:5] and reads back at bits 14:5. A write with a wrong key leaves PERIOD unchanged.
- R4: Writing exactly 0x1971 to KICK loads the counter with length × 512. Any other value written to KICK leaves the counter unchanged.
- R5: While enabled, the counter drops by one on each cycle with tick_i high. While disabled, it holds its value. COUNT returns the counter.
- R6: An expiry happens on a tick when the counter is 1 or less. In reset mode (bits 3 and 6 clear) with bit 2 set, the expiry drives wdt_rst_o active for exactly 16 clock cycles, starting the cycle after the expiring edge. The counter reloads to length × 512, and CAUSE bit 31 is set.
- R7: When polarity is 1, the reset output is active-high. When polarity is 0, it is active-low. With bit 2 clear, a timeout gives no pulse but still sets CAUSE bit 31.
- R8: In interrupt mode (bit 3), an expiry raises irq_o and gives no reset pulse. irq_o stays high until CAUSE is read.
- R9: In dual mode (bit 6 set, bit 3 clear), the first expiry raises irq_o. An expiry while irq_o is still high gives a timeout reset, as in R6.
- R10: Writing exactly 0x1209 to FORCE drives a 16-cycle reset pulse at once, whatever bit 2 is, and sets CAUSE bit 30. Other values written to FORCE have no effect.
- R11: A CAUSE read returns its bits and clears them. An event in the same cycle as the read is kept.
- R12: A valid KICK in the same cycle as an expiring tick wins: the counter reloads and no expiry takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32768 Hz count enable, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| wdt_rst_o | output | 1 | External reset output, polarity from CTRL bit 1 |
| irq_o | output | 1 | Timeout interrupt |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a reload write and the last counting tick. The bench walks the counter down to 1, then drives a valid KICK and tick_i in the same cycle. It judges the result by a COUNT of 512, no reset pulse and an empty CAUSE.

The second pair is a CAUSE read and an expiry. The bench issues the read together with the expiring tick. The read must return the old value, and a second read must then show the timeout bit.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int KEY_LO_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CAUSE  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_FORCE  = 5'h14;

  localparam logic [7:0]          CTRL_KEY   = 8'h22;
  localparam logic [KEY_LO_W-1:0] PERIOD_KEY = 5'h08;
  localparam logic [DATA_W-1:0]   KICK_KEY   = 32'h0000_1971;
  localparam logic [DATA_W-1:0]   FORCE_KEY  = 32'h0000_1209;

  localparam int CAUSE_TMO_BIT = 31;
  localparam int CAUSE_SW_BIT  = 30;

  typedef struct packed {
    logic dual;
    logic irq_mode;
    logic ext_en;
    logic pol;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int LEN_W     = 10,
  parameter int UNIT_LOG2 = 9,
  parameter int RST_LEN   = 1023,
  localparam int CNT_W    = LEN_W + UNIT_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;

  assign load     = {len_i, {UNIT_LOG2{1'b0}}};
  assign expire_o = en_i & tick_i & ~kick_i & (cnt_q <= CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= CNT_W'(RST_LEN) << UNIT_LOG2;
    else if (kick_i)          cnt_q <= load;
    else if (expire_o)        cnt_q <= load;
    else if (en_i && tick_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !kick_i) |=> $stable(cnt_q)); // R5
  AST_KICK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == $past(load))); // R4
  AST_EXPIRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(load))); // R6
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int PULSE_CYCLES = 16,
  localparam int PW = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (trig_i)          left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)    left_q <= left_q - PW'(1);
  end

  assign active_o = (left_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_o); // R10
  AST_PULSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !trig_i) |=> !active_o); // R6
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int RST_LEN = 1023,
  parameter int CNT_W   = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              kick_o,
  output logic              pulse_trig_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t             ctrl_q;
  logic [LEN_W-1:0]  len_q;
  logic              irq_q;
  logic              tmo_q, sw_q;
  logic [DATA_W-1:0] rdata_q;

  logic wr_ctrl, wr_len, sw_hit, cause_rd;
  logic irq_set, tmo_rst;

  assign wr_ctrl  = wr_en_i && addr_i == OFS_CTRL   && wdata_i[31:24] == CTRL_KEY;
  assign wr_len   = wr_en_i && addr_i == OFS_PERIOD && wdata_i[KEY_LO_W-1:0] == PERIOD_KEY;
  assign kick_o   = wr_en_i && addr_i == OFS_KICK   && wdata_i == KICK_KEY;
  assign sw_hit   = wr_en_i && addr_i == OFS_FORCE  && wdata_i == FORCE_KEY;
  assign cause_rd = rd_en_i && addr_i == OFS_CAUSE;

  // interrupt mode wins over dual; dual escalates only while irq is pending
  assign irq_set = expire_i & (ctrl_q.irq_mode | (ctrl_q.dual & ~irq_q));
  assign tmo_rst = expire_i & ~ctrl_q.irq_mode & (~ctrl_q.dual | irq_q);
  assign pulse_trig_o = sw_hit | (tmo_rst & ctrl_q.ext_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      len_q  <= LEN_W'(RST_LEN);
    end else begin
      if (wr_ctrl) ctrl_q <= '{dual: wdata_i[6], irq_mode: wdata_i[3], ext_en: wdata_i[2],
                               pol: wdata_i[1], en: wdata_i[0]};
      if (wr_len)  len_q  <= wdata_i[KEY_LO_W +: LEN_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      tmo_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      if (irq_set)       irq_q <= 1'b1;
      else if (cause_rd) irq_q <= 1'b0;
      if (tmo_rst)       tmo_q <= 1'b1;
      else if (cause_rd) tmo_q <= 1'b0;
      if (sw_hit)        sw_q  <= 1'b1;
      else if (cause_rd) sw_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        OFS_CTRL:   rdata_q <= DATA_W'({ctrl_q.dual, 2'b00, ctrl_q.irq_mode, ctrl_q.ext_en,
                                        ctrl_q.pol, ctrl_q.en});
        OFS_PERIOD: rdata_q <= DATA_W'({len_q, {KEY_LO_W{1'b0}}});
        OFS_CAUSE: begin
          rdata_q <= '0;
          rdata_q[CAUSE_TMO_BIT] <= tmo_q;
          rdata_q[CAUSE_SW_BIT]  <= sw_q;
        end
        OFS_COUNT:  rdata_q <= DATA_W'(cnt_i);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign len_o   = len_q;
  assign irq_o   = irq_q;
  assign rdata_o = rdata_q;

  AST_CTRL_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_CTRL && wdata_i[31:24] != CTRL_KEY) |=> $stable(ctrl_q)); // R2
  AST_PERIOD_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_PERIOD && wdata_i[KEY_LO_W-1:0] != PERIOD_KEY) |=> $stable(len_q)); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !cause_rd) |=> irq_q); // R8
  AST_CAUSE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_rd && !expire_i && !sw_hit) |=> (!tmo_q && !sw_q)); // R11
endmodule

// File: rtl/kwd_timer.sv
module kwd_timer
  import kwd_pkg::*;
#(
  parameter int LEN_W        = 10,
  parameter int UNIT_LOG2    = 9,
  parameter int RST_LEN      = 1023,
  parameter int PULSE_CYCLES = 16,
  localparam int CNT_W       = LEN_W + UNIT_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] cnt;
  logic             kick, expire, trig, active;

  kwd_regs #(.LEN_W(LEN_W), .RST_LEN(RST_LEN), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .expire_i(expire), .cnt_i(cnt), .ctrl_o(ctrl), .len_o(len),
    .kick_o(kick), .pulse_trig_o(trig), .irq_o, .rdata_o
  );

  kwd_counter #(.LEN_W(LEN_W), .UNIT_LOG2(UNIT_LOG2), .RST_LEN(RST_LEN)) u_counter (
    .clk_i, .rst_ni, .en_i(ctrl.en), .tick_i, .kick_i(kick), .len_i(len),
    .cnt_o(cnt), .expire_o(expire)
  );

  kwd_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i, .rst_ni, .trig_i(trig), .active_o(active)
  );

  assign wdt_rst_o = active ? ctrl.pol : ~ctrl.pol;

  AST_IRQ_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctrl.irq_mode && !trig) |=> (active == $past(active) || !active)); // R8
endmodule

// File: tb/kwd_timer_bench.sv
module kwd_timer_bench;
  import kwd_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic wdt_rst, irq;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  kwd_timer u_kwd_timer (
    .clk_i(clk), .rst_ni, .tick_i(tick), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .wdt_rst_o(wdt_rst), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic count_level(logic lvl, output int c);
    c = 0;
    for (int i = 0; i < 20; i++) begin
      if (wdt_rst === lvl) c++;
      @(negedge clk);
    end
  endtask

  task automatic arm(logic [31:0] ctrl_word);
    wr_reg(OFS_CTRL, ctrl_word);
    wr_reg(OFS_PERIOD, 32'h28);
    wr_reg(OFS_KICK, KICK_KEY);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(OFS_CTRL, d);   check("R1 ctrl", d, 0);
    rd_reg(OFS_PERIOD, d); check("R1 period", d, 32'h7FE0);
    rd_reg(OFS_COUNT, d);  check("R1 count", d, 523776);
    rd_reg(OFS_CAUSE, d);  check("R1 cause", d, 0);
    check("R1 irq", irq, 0);
    check("R1 rst", wdt_rst, 1);
  endtask

  task automatic t_keys;
    logic [31:0] d;
    wr_reg(OFS_CTRL, 32'h2100_0045); rd_reg(OFS_CTRL, d); check("R2 bad key", d, 0);
    wr_reg(OFS_CTRL, 32'h2200_0045); rd_reg(OFS_CTRL, d); check("R2 good key", d, 32'h45);
    wr_reg(OFS_CTRL, 32'h2200_0000); rd_reg(OFS_CTRL, d); check("R2 clear", d, 0);
    wr_reg(OFS_PERIOD, 32'h29); rd_reg(OFS_PERIOD, d); check("R3 bad key", d, 32'h7FE0);
    wr_reg(OFS_PERIOD, 32'h28); rd_reg(OFS_PERIOD, d); check("R3 good key", d, 32'h20);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr_reg(OFS_KICK, 32'h1970); rd_reg(OFS_COUNT, d); check("R4 bad kick", d, 523776);
    wr_reg(OFS_KICK, KICK_KEY); rd_reg(OFS_COUNT, d); check("R4 kick", d, 512);
    ticks(50); rd_reg(OFS_COUNT, d); check("R5 hold disabled", d, 512);
    wr_reg(OFS_CTRL, 32'h2200_0001);
    ticks(10); rd_reg(OFS_COUNT, d); check("R5 count down", d, 502);
  endtask

  task automatic t_expire_rst;
    logic [31:0] d; int c;
    arm(32'h2200_0005);
    ticks(511);
    check("R6 idle before expiry", wdt_rst, 1);
    ticks(1);
    count_level(1'b0, c); check("R6 pulse length", c, 16);
    rd_reg(OFS_COUNT, d); check("R6 reload", d, 512);
    rd_reg(OFS_CAUSE, d); check("R6 cause", d, 32'h8000_0000);
    rd_reg(OFS_CAUSE, d); check("R11 cleared", d, 0);
  endtask

  task automatic t_polarity;
    logic [31:0] d; int c;
    arm(32'h2200_0007);
    check("R7 high-pol idle", wdt_rst, 0);
    ticks(512);
    count_level(1'b1, c); check("R7 active-high pulse", c, 16);
    rd_reg(OFS_CAUSE, d); check("R7 cause", d, 32'h8000_0000);
    arm(32'h2200_0001);
    ticks(512);
    count_level(1'b0, c); check("R7 output disabled", c, 0);
    rd_reg(OFS_CAUSE, d); check("R7 cause without pulse", d, 32'h8000_0000);
  endtask

  task automatic t_irq;
    logic [31:0] d; int c;
    arm(32'h2200_000D);
    ticks(512);
    check("R8 irq raised", irq, 1);
    count_level(1'b0, c); check("R8 no pulse", c, 0);
    check("R8 irq held", irq, 1);
    rd_reg(OFS_CAUSE, d); check("R8 cause empty", d, 0);
    check("R8 irq cleared", irq, 0);
  endtask

  task automatic t_dual;
    logic [31:0] d; int c;
    arm(32'h2200_0045);
    ticks(512);
    check("R9 first irq", irq, 1);
    check("R9 no first reset", wdt_rst, 1);
    ticks(512);
    count_level(1'b0, c); check("R9 second reset", c, 16);
    rd_reg(OFS_CAUSE, d); check("R9 cause", d, 32'h8000_0000);
    check("R9 irq cleared", irq, 0);
  endtask

  task automatic t_force;
    logic [31:0] d; int c;
    wr_reg(OFS_CTRL, 32'h2200_0000);
    wr_reg(OFS_FORCE, 32'h1208);
    count_level(1'b0, c); check("R10 bad key", c, 0);
    wr_reg(OFS_FORCE, FORCE_KEY);
    count_level(1'b0, c); check("R10 forced pulse", c, 16);
    rd_reg(OFS_CAUSE, d); check("R10 cause", d, 32'h4000_0000);
  endtask

  task automatic t_cause_race;
    logic [31:0] d;
    arm(32'h2200_0001);
    ticks(511);
    rd = 1'b1; addr = OFS_CAUSE; tick = 1'b1;
    @(negedge clk);
    rd = 1'b0; tick = 1'b0;
    check("R11 old value on race", rdata, 0);
    rd_reg(OFS_CAUSE, d); check("R11 event kept", d, 32'h8000_0000);
  endtask

  task automatic t_kick_race;
    logic [31:0] d; int c;
    arm(32'h2200_0005);
    ticks(511);
    wr = 1'b1; addr = OFS_KICK; wdata = KICK_KEY; tick = 1'b1;
    @(negedge clk);
    wr = 1'b0; tick = 1'b0;
    count_level(1'b0, c); check("R12 no pulse", c, 0);
    rd_reg(OFS_COUNT, d); check("R12 reloaded", d, 512);
    rd_reg(OFS_CAUSE, d); check("R12 no cause", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_keys();
    t_count();
    t_expire_rst();
    t_polarity();
    t_irq();
    t_dual();
    t_force();
    t_cause_race();
    t_kick_race();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule